// File: doc/BRIEF.md
# Dual-Host Control Register Bank

This block holds a bank of 32 eight-bit registers that two hosts can reach at the same time. One host uses a two-wire I2C slave port, and the other uses a multiplexed 8-bit microcontroller bus. Writes from either host land in a control array, and every control byte is presented in parallel on a wide output bus for the rest of the chip. Reads return a separate status array at the same address, and that array is fed from a wide input bus. The value a host writes therefore cannot be read back through the same address.

The microcontroller bus shares one byte lane between address and data. An address phase, marked by the address latch enable, picks the register. The write and read strobes that follow are active low and count only while chip select is high. The I2C port keeps a register pointer. A short write transaction sets that pointer and may also carry one data byte. A later read transaction returns the status byte that the pointer selects.

When both ports write in the same clock cycle, the parallel write is applied first and the I2C write is held for one cycle. No write from either port is lost.

Top module: `dual_host_regbank`

## Requirements
- R1: Reset clears all 32 control bytes to 00h. Reset also leaves the parallel output enable and the SDA pull-down off.
- R2: While `pbus_ale` is high, bits 4:0 of `pbus_d_i` are captured as the parallel register address. Bits 7:5 are ignored.
- R3: A rising edge of (`pbus_cs` high AND `pbus_wr_n` low, with `pbus_ale` low) writes `pbus_d_i` into the control byte at the latched address. The new value appears on `ctrl_o` one clock later. A write strobe while `pbus_cs` is low changes nothing.
- R4: `pbus_d_oe` is high exactly one clock after a cycle in which `pbus_cs` is high and `pbus_rd_n` is low, and low otherwise. While it is high, `pbus_d_o` carries the status byte at the latched address, never the control byte.
- R5: The I2C transaction start, 3Eh, register byte, data byte, stop writes the data byte into the control byte selected by the register byte. All three bytes are acknowledged.
- R6: After a write transaction of start, 3Eh, register byte, stop, the transaction start, 3Fh, then eight clocked bits returns the status byte at that register, most significant bit first.
- R7: An I2C address byte other than 3Eh or 3Fh is not acknowledged, and the bytes that follow in that transaction change no control byte.
- R8: Bits 7:5 of the I2C register byte are ignored. Only bits 4:0 select the register.
- R9: When a parallel write and an I2C write fall in the same cycle, the parallel write is applied in that cycle and the I2C write in the next. Both values end up stored.
- R10: The I2C port changes its SDA pull-down only after a falling SCL edge, and it releases the pull-down on a stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line, sampled |
| sda_i | input | 1 | I2C data line, sampled |
| sda_oe | output | 1 | Pulls SDA low when high (open drain) |
| pbus_ale | input | 1 | Parallel bus address latch enable |
| pbus_cs | input | 1 | Parallel bus chip select, active high |
| pbus_wr_n | input | 1 | Parallel bus write strobe, active low |
| pbus_rd_n | input | 1 | Parallel bus read strobe, active low |
| pbus_d_i | input | 8 | Parallel bus address/data in |
| pbus_d_o | output | 8 | Parallel bus read data out |
| pbus_d_oe | output | 1 | Parallel bus output enable |
| stat_i | input | 256 | Status bytes, byte n at bits 8n+7:8n |
| ctrl_o | output | 256 | Control bytes, byte n at bits 8n+7:8n |

## Verification
The assertions assume that the parallel bus inputs are synchronous to `clk`. They also assume that each SCL level lasts well beyond the three-cycle synchronizer delay, and that SDA changes from the master only while SCL is low, except for start and stop conditions. The bench drives every bus input on the falling clock edge. It holds each SCL half period for twelve clocks and waits four clocks after every SCL fall before it moves SDA. A sweep moves a parallel write strobe across the cycle in which an I2C write commits, so that the same-cycle case is hit.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_COUNT   = 32;
  localparam int BYTE_W      = 8;
  localparam logic [6:0] SLAVE_ID = 7'h1F;

  typedef enum logic [2:0] {
    I2C_IDLE,
    I2C_DEV,
    I2C_REG,
    I2C_WDAT,
    I2C_ACK,
    I2C_RDAT,
    I2C_RACK
  } i2c_state_t;
endpackage

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [6:0] DEV_ID = SLAVE_ID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ptr,
  input  logic [7:0]        rd_data
);
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;
  i2c_state_t st, nxt_st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic ack_pend;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= I2C_IDLE;
      nxt_st   <= I2C_IDLE;
      cnt      <= '0;
      sh       <= '0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st       <= I2C_DEV;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
      end else if (stop_det) begin
        st       <= I2C_IDLE;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          I2C_DEV, I2C_REG, I2C_WDAT: begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0;
              case (st)
                I2C_DEV: begin
                  if (sh[6:0] == DEV_ID) begin
                    ack_pend <= 1'b1;
                    nxt_st   <= sda_s ? I2C_RDAT : I2C_REG;
                  end else begin
                    st <= I2C_IDLE;
                  end
                end
                I2C_REG: begin
                  ptr      <= {sh[ADDR_W-2:0], sda_s};
                  ack_pend <= 1'b1;
                  nxt_st   <= I2C_WDAT;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= {sh[6:0], sda_s};
                  ack_pend <= 1'b1;
                  nxt_st   <= I2C_IDLE;
                end
              endcase
            end
          end
          I2C_RDAT: cnt <= cnt + 4'd1;
          I2C_RACK: st  <= I2C_IDLE;
          default: ;
        endcase
      end else if (scl_fall) begin
        if (ack_pend) begin
          sda_oe   <= 1'b1;
          ack_pend <= 1'b0;
          st       <= I2C_ACK;
        end else begin
          case (st)
            I2C_ACK: begin
              sda_oe <= 1'b0;
              st     <= nxt_st;
              cnt    <= '0;
              if (nxt_st == I2C_RDAT) begin
                sh     <= {rd_data[6:0], 1'b0};
                sda_oe <= ~rd_data[7];
              end
            end
            I2C_RDAT: begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= I2C_RACK;
              end else begin
                sda_oe <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pbus_port.sv
module pbus_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              cs,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_data
);
  logic wr_act, wr_q;
  logic unused_hi_bits;

  assign unused_hi_bits = ^d_i[DATA_W-1:ADDR_W];
  assign wr_act = cs & ~wr_n & ~ale;
  assign we     = wr_act & ~wr_q;
  assign wdata  = d_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      wr_q <= 1'b0;
      d_oe <= 1'b0;
      d_o  <= '0;
    end else begin
      if (ale) addr <= d_i[ADDR_W-1:0];
      wr_q <= wr_act;
      d_oe <= cs & ~rd_n;
      d_o  <= rd_data;
    end
  end
endmodule

// File: rtl/ctrl_store.sv
module ctrl_store #(
  parameter int NREG   = 32,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   p_we,
  input  logic [ADDR_W-1:0]      p_addr,
  input  logic [DATA_W-1:0]      p_data,
  input  logic                   i_we,
  input  logic [ADDR_W-1:0]      i_addr,
  input  logic [DATA_W-1:0]      i_data,
  output logic [NREG*DATA_W-1:0] ctrl_flat
);
  logic [DATA_W-1:0] mem [NREG];
  logic              hold_v;
  logic [ADDR_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
      hold_v <= 1'b0;
      hold_a <= '0;
      hold_d <= '0;
    end else if (p_we) begin
      mem[p_addr] <= p_data;
      if (i_we) begin
        hold_v <= 1'b1;
        hold_a <= i_addr;
        hold_d <= i_data;
      end
    end else if (hold_v) begin
      mem[hold_a] <= hold_d;
      hold_v <= i_we;
      hold_a <= i_addr;
      hold_d <= i_data;
    end else if (i_we) begin
      mem[i_addr] <= i_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign ctrl_flat[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/dual_host_regbank.sv
module dual_host_regbank
  import regbank_pkg::*;
#(
  parameter int NREG   = REG_COUNT,
  parameter int DATA_W = BYTE_W,
  parameter logic [6:0] DEV_ID = SLAVE_ID
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic                   pbus_ale,
  input  logic                   pbus_cs,
  input  logic                   pbus_wr_n,
  input  logic                   pbus_rd_n,
  input  logic [DATA_W-1:0]      pbus_d_i,
  output logic [DATA_W-1:0]      pbus_d_o,
  output logic                   pbus_d_oe,
  input  logic [NREG*DATA_W-1:0] stat_i,
  output logic [NREG*DATA_W-1:0] ctrl_o
);
  localparam int ADDR_W = $clog2(NREG);

  logic              p_we, i_we;
  logic [ADDR_W-1:0] p_addr, i_addr, i_ptr;
  logic [DATA_W-1:0] p_data, i_data, p_stat, i_stat;

  assign p_stat = stat_i[p_addr*DATA_W +: DATA_W];
  assign i_stat = stat_i[i_ptr*DATA_W +: DATA_W];

  pbus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pbus (
    .clk(clk), .rst(rst), .ale(pbus_ale), .cs(pbus_cs), .wr_n(pbus_wr_n),
    .rd_n(pbus_rd_n), .d_i(pbus_d_i), .d_o(pbus_d_o), .d_oe(pbus_d_oe),
    .we(p_we), .addr(p_addr), .wdata(p_data), .rd_data(p_stat)
  );

  i2c_reg_port #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .wr_en(i_we), .wr_addr(i_addr), .wr_data(i_data), .ptr(i_ptr),
    .rd_data(i_stat)
  );

  ctrl_store #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .p_we(p_we), .p_addr(p_addr), .p_data(p_data),
    .i_we(i_we), .i_addr(i_addr), .i_data(i_data), .ctrl_flat(ctrl_o)
  );
endmodule

// File: rtl/dual_host_regbank_chk.sv
module dual_host_regbank_chk #(
  parameter int NREG   = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_i,
  input logic                   sda_oe,
  input logic                   pbus_cs,
  input logic                   pbus_rd_n,
  input logic                   pbus_d_oe,
  input logic                   p_we,
  input logic [ADDR_W-1:0]      p_addr,
  input logic [DATA_W-1:0]      p_data,
  input logic                   i_we,
  input logic [ADDR_W-1:0]      i_addr,
  input logic [DATA_W-1:0]      i_data,
  input logic [NREG*DATA_W-1:0] ctrl_o
);
  logic [ADDR_W-1:0] pa_q, ia_q, ia_q2;
  logic [DATA_W-1:0] pd_q, id_q, id_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q <= '0; ia_q <= '0; ia_q2 <= '0;
      pd_q <= '0; id_q <= '0; id_q2 <= '0;
    end else begin
      pa_q <= p_addr; pd_q <= p_data;
      ia_q <= i_addr; id_q <= i_data;
      ia_q2 <= ia_q;  id_q2 <= id_q;
    end
  end

  // R4
  rd_oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    pbus_d_oe |-> $past(pbus_cs && !pbus_rd_n));

  // R4
  rd_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pbus_cs && !pbus_rd_n) |=> pbus_d_oe);

  // R3
  pwrite_land_chk: assert property (@(posedge clk) disable iff (rst)
    p_we |=> (ctrl_o[pa_q*DATA_W +: DATA_W] == pd_q));

  // R5
  iwrite_land_chk: assert property (@(posedge clk) disable iff (rst)
    (i_we && !p_we) |=> (ctrl_o[ia_q*DATA_W +: DATA_W] == id_q));

  // R9
  collide_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (i_we && p_we) |=> ##1 (ctrl_o[ia_q2*DATA_W +: DATA_W] == id_q2));

  // R10
  sda_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_i));
endmodule

bind dual_host_regbank dual_host_regbank_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .pbus_cs(pbus_cs), .pbus_rd_n(pbus_rd_n), .pbus_d_oe(pbus_d_oe),
  .p_we(p_we), .p_addr(p_addr), .p_data(p_data),
  .i_we(i_we), .i_addr(i_addr), .i_data(i_data), .ctrl_o(ctrl_o)
);

// File: tb/dual_host_regbank_bench.sv
module dual_host_regbank_bench;
  localparam int NREG = 32;
  localparam int DW   = 8;
  localparam int H    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  logic pbus_ale = 1'b0, pbus_cs = 1'b0, pbus_wr_n = 1'b1, pbus_rd_n = 1'b1;
  logic [DW-1:0] pbus_d_i = '0;
  logic [DW-1:0] pbus_d_o;
  logic pbus_d_oe;
  logic [NREG*DW-1:0] stat_i = '0;
  logic [NREG*DW-1:0] ctrl_o;

  dual_host_regbank u_dual_host_regbank (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pbus_ale(pbus_ale), .pbus_cs(pbus_cs), .pbus_wr_n(pbus_wr_n),
    .pbus_rd_n(pbus_rd_n), .pbus_d_i(pbus_d_i), .pbus_d_o(pbus_d_o),
    .pbus_d_oe(pbus_d_oe), .stat_i(stat_i), .ctrl_o(ctrl_o)
  );

  int checks = 0, fails = 0, rise_cnt = 0;
  logic [7:0] ctrl_m [NREG];
  logic [7:0] stat_m [NREG];

  always @(posedge scl_m) rise_cnt++;

  function automatic logic [7:0] ctrl_at(int a);
    return ctrl_o[a*DW +: DW];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < NREG; a++) chk(req, ctrl_at(a), ctrl_m[a]);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic i2c_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(4);
    end
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H/2);
    ack = ~sda_line; wait_clk(H/2);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic i2c_recv(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H);
      scl_m = 1'b1; wait_clk(H/2);
      b[i] = sda_line; wait_clk(H/2);
      scl_m = 1'b0; wait_clk(4);
    end
    wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic i2c_wr(input logic [7:0] regb, input logic [7:0] dat);
    logic ack;
    i2c_start;
    i2c_send(8'h3E, ack); chk("R5 dev ack", ack, 1);
    i2c_send(regb, ack);  chk("R5 reg ack", ack, 1);
    i2c_send(dat, ack);   chk("R5 data ack", ack, 1);
    i2c_stop;
    chk("R10 released after stop", sda_oe, 0);
    ctrl_m[regb[4:0]] = dat;
  endtask

  task automatic i2c_rd(input logic [7:0] regb);
    logic ack;
    logic [7:0] got;
    i2c_start;
    i2c_send(8'h3E, ack);
    i2c_send(regb, ack);
    i2c_stop;
    i2c_start;
    i2c_send(8'h3F, ack); chk("R6 read dev ack", ack, 1);
    i2c_recv(got);
    i2c_stop;
    chk("R6 R8 read status", got, stat_m[regb[4:0]]);
    chk("R10 released after stop", sda_oe, 0);
  endtask

  task automatic p_latch(input logic [7:0] a);
    pbus_ale = 1'b1; pbus_d_i = a; wait_clk(1);
    pbus_ale = 1'b0;
  endtask

  task automatic p_write(input logic [7:0] a, input logic [7:0] d);
    p_latch(a);
    pbus_d_i = d; pbus_cs = 1'b1; pbus_wr_n = 1'b0; wait_clk(1);
    pbus_wr_n = 1'b1; pbus_cs = 1'b0; wait_clk(1);
    ctrl_m[a[4:0]] = d;
    chk("R2 R3 parallel write", ctrl_at(a[4:0]), d);
  endtask

  task automatic p_read(input logic [7:0] a);
    p_latch(a);
    chk("R4 oe idle", pbus_d_oe, 0);
    pbus_cs = 1'b1; pbus_rd_n = 1'b0; wait_clk(2);
    chk("R4 oe during read", pbus_d_oe, 1);
    chk("R4 read status byte", pbus_d_o, stat_m[a[4:0]]);
    pbus_rd_n = 1'b1; pbus_cs = 1'b0; wait_clk(1);
    chk("R4 oe after read", pbus_d_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary;
  end

  initial begin
    logic ack;
    int tgt;
    void'($urandom(32'd1234));
    for (int a = 0; a < NREG; a++) begin
      stat_m[a] = 8'($urandom);
      stat_i[a*DW +: DW] = stat_m[a];
      ctrl_m[a] = 8'h00;
    end
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    check_all("R1 reset ctrl");
    chk("R1 reset oe", pbus_d_oe, 0);
    chk("R1 reset sda", sda_oe, 0);

    // R2 upper address bits ignored
    p_write(8'hA3, 8'h5C);
    // R4 read at same address returns status, not control
    p_write(8'h09, 8'h11);
    p_read(8'h09);

    // R3 strobe without chip select ignored
    p_latch(8'h07);
    pbus_d_i = 8'hEE; pbus_wr_n = 1'b0; wait_clk(1);
    pbus_wr_n = 1'b1; wait_clk(1);
    chk("R3 cs low write ignored", ctrl_at(7), ctrl_m[7]);
    pbus_rd_n = 1'b0; wait_clk(2);
    chk("R4 cs low read no oe", pbus_d_oe, 0);
    pbus_rd_n = 1'b1; wait_clk(1);

    // R5 R6 directed I2C
    i2c_wr(8'h04, 8'hC3);
    chk("R5 i2c write", ctrl_at(4), 8'hC3);
    i2c_rd(8'h1F);
    // R8 high register bits ignored
    i2c_wr(8'hE2, 8'h77);
    chk("R8 i2c masked reg", ctrl_at(2), 8'h77);

    // R7 foreign device address
    i2c_start;
    i2c_send(8'h50, ack);
    chk("R7 foreign addr nack", ack, 0);
    i2c_send(8'h05, ack);
    i2c_send(8'h99, ack);
    i2c_stop;
    chk("R7 no write", ctrl_at(5), ctrl_m[5]);
    i2c_start;
    i2c_send(8'h3C, ack);
    chk("R7 near addr nack", ack, 0);
    i2c_stop;

    // R9 parallel write swept across I2C commit
    for (int k = 0; k < 8; k++) begin
      p_latch(8'h15);
      tgt = rise_cnt + 26;
      fork
        i2c_wr(8'h14, 8'hA0 + 8'(k));
        begin
          wait (rise_cnt == tgt);
          wait_clk(k);
          pbus_d_i = 8'h50 + 8'(k); pbus_cs = 1'b1; pbus_wr_n = 1'b0;
          wait_clk(1);
          pbus_wr_n = 1'b1; pbus_cs = 1'b0;
        end
      join
      ctrl_m[21] = 8'h50 + 8'(k);
      wait_clk(2);
      chk("R9 i2c side kept", ctrl_at(20), ctrl_m[20]);
      chk("R9 parallel side kept", ctrl_at(21), ctrl_m[21]);
    end

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] ra, rd;
      ra = 8'($urandom);
      rd = 8'($urandom);
      case ($urandom % 4)
        0: p_write(ra, rd);
        1: p_read(ra);
        2: begin
          i2c_wr(ra, rd);
          chk("R5 R8 random i2c write", ctrl_at(ra[4:0]), rd);
        end
        default: i2c_rd(ra);
      endcase
    end
    check_all("R3 R5 final ctrl");
    summary;
  end
endmodule